// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting FIFO Engine

This block sits between a host register port and a byte-wide NAND data bus. It moves a programmed number of bytes in one direction through a 64-byte FIFO. For a read, it fetches flash bytes ahead into the FIFO, and the host pulls them out as 32-bit words. For a write, the host pushes 16-bit words into the FIFO, and the engine drains them to the flash one byte per ready cycle. Command and address cycles are not part of this block. Error correction is computed elsewhere.

Software starts a transfer with a direction, a byte count and a DMA enable, then polls one status word. That word carries two fields: the number of bytes the host may move now, and the number of bytes the transfer still has to complete. When DMA is enabled, a request line is raised once for each frame of up to 64 bytes. A start issued while a transfer is in flight is refused with a one-cycle reject pulse. A stop aborts the transfer and returns the engine to idle.

Top module: `nand_pfq_engine`

## Requirements
- R1: After reset, `status_o` is zero and `dma_req_o`, `start_rej_o`, `flash_rd_o` and `flash_wr_o` are all low.
- R2: A `start_i` accepted while idle loads the direction (`cfg_write_i` 0 = read, 1 = write) and the count. In read mode, count bits 1:0 are cleared. In write mode, count bit 0 is cleared. A count that becomes zero leaves the engine idle.
- R3: `status_o` bits 13:0 hold the remaining count and bits 30:24 hold the available bytes. In read mode the available bytes are the FIFO fill; in write mode they are the FIFO free space. All other bits are zero, and the available field reads 0 while idle.
- R4: In read mode, `flash_rd_o` pulses once per cycle when `flash_rdy_i` is high, the FIFO is not full and bytes remain to be fetched. Exactly the loaded count is fetched, and the fill never exceeds 64.
- R5: In read mode, `hrd_data_o` shows the next four FIFO bytes, the earliest in bits 7:0. `hrd_i` is accepted only when at least 4 bytes are available; otherwise it changes nothing.
- R6: In write mode, `hwr_i` is accepted only when at least 2 bytes of FIFO space are free and at least 2 bytes of the count remain unpushed. Bits 7:0 of the word reach the flash before bits 15:8. A refused write is dropped.
- R7: In write mode, `flash_wr_o` pulses once per cycle when `flash_rdy_i` is high and the FIFO is not empty, carrying the oldest byte on `flash_dout_o`.
- R8: In read mode, the remaining count drops by 4 for each accepted host read. In write mode, it drops by 1 for each flash write. It never rises except at an accepted start, and the engine is idle when it reaches 0.
- R9: A `start_i` while the remaining count is non-zero raises `start_rej_o` in the next cycle and changes neither the configuration nor the counts.
- R10: `stop_i` empties the FIFO, zeroes the counts and drops the DMA request, so `status_o` is 0 the next cycle. It takes precedence over a simultaneous start.
- R11: With DMA enabled, `dma_req_o` rises when the FIFO holds (read) or has room for (write) min(64, bytes the host still has to move). It stays high until the host has moved that many bytes, then falls for at least one cycle.
- R12: `flash_rd_o` and `flash_wr_o` are never high together and are only high while `flash_rdy_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request (one-cycle pulse) |
| stop_i | input | 1 | Abort and return to idle |
| cfg_write_i | input | 1 | Direction: 0 read, 1 write |
| cfg_count_i | input | 14 | Transfer byte count |
| cfg_dma_i | input | 1 | Enable per-frame DMA request |
| start_rej_o | output | 1 | Start refused because busy |
| status_o | output | 32 | Available bytes [30:24], remaining count [13:0] |
| hrd_i | input | 1 | Host pops one 32-bit word |
| hrd_data_o | output | 32 | Word at the FIFO head |
| hwr_i | input | 1 | Host pushes one 16-bit word |
| hwr_data_i | input | 16 | Word to push |
| dma_req_o | output | 1 | DMA frame request |
| flash_rdy_i | input | 1 | Flash bus can take a beat this cycle |
| flash_rd_o | output | 1 | Byte captured from flash this cycle |
| flash_din_i | input | 8 | Flash read data |
| flash_wr_o | output | 1 | Byte written to flash this cycle |
| flash_dout_o | output | 8 | Flash write data |

## Verification
In read mode, a flash fetch and a host word pop can land in the same cycle. The FIFO fill and pointers must then take the +1 and the −4 together without losing or reordering a byte. The streaming test provokes this by holding the flash bus ready for a 256-byte read while the host pops a word in every cycle that shows four bytes available. It judges the result by comparing every popped word against the byte pattern the flash model produced, and by checking that the remaining count ends at zero.

// File: rtl/nand_pfq_pkg.sv
// Shared constants and types for the NAND prefetch/write-posting engine.
// Assumes a byte-wide flash bus and a fixed 32-bit status word layout.
package nand_pfq_pkg;
    localparam int CNT_W     = 14;  // width of the remaining-count field
    localparam int AVAIL_W   = 7;   // width of the available-bytes field
    localparam int AVAIL_LSB = 24;  // bit position of the available field
    localparam int HRD_BYTES = 4;   // bytes per host read word
    localparam int HWR_BYTES = 2;   // bytes per host write word
    localparam int LANES     = 4;   // widest beat into or out of the FIFO

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } pfq_dir_e;
endpackage

// File: rtl/nand_pfq_fifo.sv
// Byte FIFO with multi-byte push and pop. Each cycle it accepts 0..LANES
// bytes and releases 0..LANES bytes. It always shows the LANES bytes at the
// head. Assumes DEPTH is a power of two and that the caller never pushes
// past full or pops past empty. A flush empties it in one cycle.
module nand_pfq_fifo #(
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1),
    parameter int N_W   = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [N_W-1:0]     push_n,
    input  logic [8*LANES-1:0] push_data,
    input  logic [N_W-1:0]     pop_n,
    output logic [8*LANES-1:0] head_data,
    output logic [LVL_W-1:0]   level
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Advance pointers and fill level; a flush or reset empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            level  <= level + LVL_W'(push_n) - LVL_W'(pop_n);
        end
    end

    // Store the pushed bytes at consecutive slots starting at the write pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(push_n)) begin
                mem[wr_ptr + PTR_W'(i)] <= push_data[8*i +: 8];
            end
        end
    end

    // Present the head bytes, oldest in the lowest lane.
    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head_data[8*g +: 8] = mem[rd_ptr + PTR_W'(g)];
    end
endmodule

// File: rtl/nand_pfq_flash.sv
// Flash-side beat generator. In read mode it captures one byte whenever the
// bus is ready, the FIFO has space and bytes remain to fetch. In write mode
// it emits the oldest FIFO byte whenever the bus is ready and the FIFO is
// not empty. Assumes the flash completes a beat in the cycle flash_rdy_i
// is high.
module nand_pfq_flash #(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             dir_wr,
    input  logic             fetch_pending,
    input  logic [LVL_W-1:0] level,
    input  logic             flash_rdy_i,
    input  logic [7:0]       head_byte,
    output logic             flash_rd_o,
    output logic             flash_wr_o,
    output logic [7:0]       flash_dout_o
);
    // Decide which flash beat, if any, happens this cycle.
    always_comb begin
        flash_rd_o   = !dir_wr && fetch_pending && (level < LVL_W'(DEPTH)) && flash_rdy_i;
        flash_wr_o   = dir_wr && (level != '0) && flash_rdy_i;
        flash_dout_o = head_byte;
    end
endmodule

// File: rtl/nand_pfq_dma.sv
// Per-frame DMA request tracker. A frame opens when the FIFO holds (read) or
// can take (write) min(FRAME_BYTES, bytes the host still has to move). It
// closes once the host has moved that many bytes. Assumes FRAME_BYTES does
// not exceed the FIFO depth. A frame never opens in a cycle with a host
// access, so its size is always sized against a stable fill.
module nand_pfq_dma #(
    parameter int FIFO_BYTES  = 64,
    parameter int FRAME_BYTES = 64,
    parameter int CNT_W       = 14,
    parameter int LVL_W       = $clog2(FIFO_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             dir_wr,
    input  logic [LVL_W-1:0] level,
    input  logic [CNT_W-1:0] host_left,
    input  logic             host_acc,
    input  logic [2:0]       acc_bytes,
    output logic             dma_req_o
);
    logic             in_frame;
    logic [CNT_W-1:0] frame_left;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] room;
    logic             ready_to_open;

    // Size of the next frame and whether the FIFO can serve it now.
    always_comb begin
        need          = (host_left < CNT_W'(FRAME_BYTES)) ? host_left : CNT_W'(FRAME_BYTES);
        room          = dir_wr ? CNT_W'(LVL_W'(FIFO_BYTES) - level) : CNT_W'(level);
        ready_to_open = enable && (host_left != '0) && (room >= need) && !host_acc;
    end

    // Open a frame, count host bytes against it, and close it when done.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_frame   <= 1'b0;
            frame_left <= '0;
        end else if (in_frame) begin
            if (host_acc) begin
                if (frame_left <= CNT_W'(acc_bytes)) begin
                    in_frame   <= 1'b0;
                    frame_left <= '0;
                end else begin
                    frame_left <= frame_left - CNT_W'(acc_bytes);
                end
            end
        end else if (ready_to_open) begin
            in_frame   <= 1'b1;
            frame_left <= need;
        end
    end

    assign dma_req_o = in_frame;
endmodule

// File: rtl/nand_pfq_engine.sv
// Top of the NAND prefetch/write-posting engine. It holds the transfer
// configuration and the two byte counters: bytes left on the flash side and
// bytes left on the host side. It gates host accesses and builds the status
// word. Assumes the host moves 32-bit words in read mode and 16-bit words
// in write mode.
module nand_pfq_engine
    import nand_pfq_pkg::*;
#(
    parameter int FIFO_BYTES  = 64,
    parameter int FRAME_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             cfg_write_i,
    input  logic [CNT_W-1:0] cfg_count_i,
    input  logic             cfg_dma_i,
    output logic             start_rej_o,
    output logic [31:0]      status_o,
    input  logic             hrd_i,
    output logic [31:0]      hrd_data_o,
    input  logic             hwr_i,
    input  logic [15:0]      hwr_data_i,
    output logic             dma_req_o,
    input  logic             flash_rdy_i,
    output logic             flash_rd_o,
    input  logic [7:0]       flash_din_i,
    output logic             flash_wr_o,
    output logic [7:0]       flash_dout_o
);
    localparam int LVL_W = $clog2(FIFO_BYTES + 1);
    localparam int N_W   = $clog2(LANES + 1);

    pfq_dir_e         dir_q;
    logic             dma_en_q;
    logic [CNT_W-1:0] flash_left;
    logic [CNT_W-1:0] host_left;
    logic [CNT_W-1:0] remaining;
    logic             busy;
    logic             dir_wr;
    logic             start_ok;
    logic [CNT_W-1:0] start_count;

    logic [LVL_W-1:0]   level;
    logic [LVL_W-1:0]   free_bytes;
    logic [8*LANES-1:0] head_data;
    logic [N_W-1:0]     push_n;
    logic [N_W-1:0]     pop_n;
    logic [8*LANES-1:0] push_data;
    logic               flush;

    logic             rd_acc;
    logic             wr_acc;
    logic             host_acc;
    logic [2:0]       acc_bytes;
    logic [LVL_W-1:0] avail;

    // Transfer progress and the gating of host accesses.
    always_comb begin
        dir_wr      = (dir_q == DIR_WRITE);
        remaining   = dir_wr ? flash_left : host_left;
        busy        = (remaining != '0);
        free_bytes  = LVL_W'(FIFO_BYTES) - level;
        start_ok    = start_i && !stop_i && !busy;
        start_count = cfg_write_i ? (cfg_count_i & ~CNT_W'(HWR_BYTES - 1))
                                  : (cfg_count_i & ~CNT_W'(HRD_BYTES - 1));
        rd_acc      = busy && !dir_wr && hrd_i && (level >= LVL_W'(HRD_BYTES));
        wr_acc      = busy && dir_wr && hwr_i && (host_left >= CNT_W'(HWR_BYTES))
                      && (free_bytes >= LVL_W'(HWR_BYTES));
        host_acc    = rd_acc || wr_acc;
        acc_bytes   = rd_acc ? 3'(HRD_BYTES) : (wr_acc ? 3'(HWR_BYTES) : 3'd0);
        flush       = stop_i || start_ok;
    end

    // Route the FIFO push and pop ports according to the direction.
    always_comb begin
        if (dir_wr) begin
            push_n    = wr_acc ? N_W'(HWR_BYTES) : '0;
            push_data = {{(8*LANES-16){1'b0}}, hwr_data_i};
            pop_n     = flash_wr_o ? N_W'(1) : '0;
        end else begin
            push_n    = flash_rd_o ? N_W'(1) : '0;
            push_data = {{(8*LANES-8){1'b0}}, flash_din_i};
            pop_n     = rd_acc ? N_W'(HRD_BYTES) : '0;
        end
    end

    // Load, advance or clear the configuration and both byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_i) begin
            dir_q      <= DIR_READ;
            dma_en_q   <= 1'b0;
            flash_left <= '0;
            host_left  <= '0;
        end else if (start_ok) begin
            dir_q      <= cfg_write_i ? DIR_WRITE : DIR_READ;
            dma_en_q   <= cfg_dma_i;
            flash_left <= start_count;
            host_left  <= start_count;
        end else begin
            if (flash_rd_o || flash_wr_o) begin
                flash_left <= flash_left - CNT_W'(1);
            end
            if (host_acc) begin
                host_left <= host_left - CNT_W'(acc_bytes);
            end
        end
    end

    // Flag a start that arrived while a transfer was still in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_rej_o <= 1'b0;
        end else begin
            start_rej_o <= start_i && !stop_i && busy;
        end
    end

    // Assemble the status word from the two fixed fields.
    always_comb begin
        avail    = busy ? (dir_wr ? free_bytes : level) : '0;
        status_o = '0;
        status_o[CNT_W-1:0]             = remaining;
        status_o[AVAIL_LSB +: AVAIL_W]  = AVAIL_W'(avail);
        hrd_data_o = 32'(head_data);
    end

    nand_pfq_fifo #(
        .DEPTH (FIFO_BYTES),
        .LANES (LANES)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_n    (push_n),
        .push_data (push_data),
        .pop_n     (pop_n),
        .head_data (head_data),
        .level     (level)
    );

    nand_pfq_flash #(
        .DEPTH (FIFO_BYTES)
    ) u_flash (
        .dir_wr        (dir_wr),
        .fetch_pending (!dir_wr && (flash_left != '0)),
        .level         (level),
        .flash_rdy_i   (flash_rdy_i),
        .head_byte     (head_data[7:0]),
        .flash_rd_o    (flash_rd_o),
        .flash_wr_o    (flash_wr_o),
        .flash_dout_o  (flash_dout_o)
    );

    nand_pfq_dma #(
        .FIFO_BYTES  (FIFO_BYTES),
        .FRAME_BYTES (FRAME_BYTES),
        .CNT_W       (CNT_W)
    ) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .enable    (dma_en_q && busy),
        .dir_wr    (dir_wr),
        .level     (level),
        .host_left (host_left),
        .host_acc  (host_acc),
        .acc_bytes (acc_bytes),
        .dma_req_o (dma_req_o)
    );
endmodule

// File: rtl/nand_pfq_chk.sv
// Protocol checker for the engine, watching its ports only. Bound to the top.
module nand_pfq_chk #(
    parameter int FIFO_BYTES = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        stop_i,
    input logic        start_rej_o,
    input logic [31:0] status_o,
    input logic        dma_req_o,
    input logic        flash_rdy_i,
    input logic        flash_rd_o,
    input logic        flash_wr_o
);
    // R4
    fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[30:24] <= 7'(FIFO_BYTES));

    // R12
    flash_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_rd_o && flash_wr_o));

    // R12
    flash_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_rd_o || flash_wr_o) |-> flash_rdy_i);

    // R9
    reject_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rej_o |-> ($past(status_o[13:0]) != 14'd0));

    // R10
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (status_o == 32'd0) && !dma_req_o);

    // R8
    remain_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) |-> (status_o[13:0] <= $past(status_o[13:0])));

    // R11
    dma_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> (status_o[13:0] != 14'd0));

    // R3
    idle_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[13:0] == 14'd0) |-> (status_o[30:24] == 7'd0));
endmodule

bind nand_pfq_engine nand_pfq_chk #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_rej_o (start_rej_o),
    .status_o    (status_o),
    .dma_req_o   (dma_req_o),
    .flash_rdy_i (flash_rdy_i),
    .flash_rd_o  (flash_rd_o),
    .flash_wr_o  (flash_wr_o)
);

// File: tb/nand_pfq_engine_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module nand_pfq_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        cfg_write = 1'b0;
    logic [13:0] cfg_count = '0;
    logic        cfg_dma = 1'b0;
    logic        start_rej;
    logic [31:0] status;
    logic        hrd = 1'b0;
    logic [31:0] hrd_data;
    logic        hwr = 1'b0;
    logic [15:0] hwr_data = '0;
    logic        dma_req;
    logic        flash_rdy = 1'b0;
    logic        flash_rd;
    logic [7:0]  flash_din;
    logic        flash_wr;
    logic [7:0]  flash_dout;

    int n_checks = 0;
    int n_fail   = 0;

    logic        fl_clr = 1'b0;
    logic [13:0] fl_idx;
    logic [7:0]  wcap [256];
    int          wcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_pfq_engine u_nand_pfq_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .stop_i       (stop),
        .cfg_write_i  (cfg_write),
        .cfg_count_i  (cfg_count),
        .cfg_dma_i    (cfg_dma),
        .start_rej_o  (start_rej),
        .status_o     (status),
        .hrd_i        (hrd),
        .hrd_data_o   (hrd_data),
        .hwr_i        (hwr),
        .hwr_data_i   (hwr_data),
        .dma_req_o    (dma_req),
        .flash_rdy_i  (flash_rdy),
        .flash_rd_o   (flash_rd),
        .flash_din_i  (flash_din),
        .flash_wr_o   (flash_wr),
        .flash_dout_o (flash_dout)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    // Flash model: serves a byte pattern on reads, records bytes on writes.
    assign flash_din = pat(int'(fl_idx));
    always @(posedge clk) begin
        if (fl_clr) begin
            fl_idx <= '0;
            wcnt   <= 0;
        end else begin
            if (flash_rd) fl_idx <= fl_idx + 14'd1;
            if (flash_wr) begin
                wcap[wcnt[7:0]] <= flash_dout;
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_model();
        @(negedge clk) fl_clr = 1'b1;
        @(negedge clk) fl_clr = 1'b0;
    endtask

    task automatic start_xfer(input logic wr, input int cnt, input logic dma);
        @(negedge clk);
        cfg_write = wr; cfg_count = 14'(cnt); cfg_dma = dma; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic stop_xfer();
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
    endtask

    task automatic pull_word(output logic [31:0] w);
        int guard = 0;
        @(negedge clk);
        while (status[30:24] < 7'd4 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        w = hrd_data;
        hrd = 1'b1;
        @(negedge clk) hrd = 1'b0;
    endtask

    task automatic push_half(input logic [15:0] d);
        int guard = 0;
        @(negedge clk);
        while (status[30:24] < 7'd2 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        hwr_data = d;
        hwr = 1'b1;
        @(negedge clk) hwr = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input int base);
        return {pat(base + 3), pat(base + 2), pat(base + 1), pat(base)};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 status", int'(status), 0);
        check("R1 idle outputs", int'({dma_req, start_rej, flash_rd, flash_wr}), 0);
    endtask

    task automatic t_read_basic();
        logic [31:0] w;
        clr_model();
        flash_rdy = 1'b1;
        start_xfer(1'b0, 18, 1'b0);
        check("R2 read count masked", int'(status[13:0]), 16);
        for (int i = 0; i < 4; i++) begin
            pull_word(w);
            check("R5 read word order", int'(w), int'(exp_word(4 * i)));
        end
        check("R8 read remaining done", int'(status[13:0]), 0);
        check("R3 idle avail", int'(status[30:24]), 0);
        check("R4 fetched exactly count", int'(fl_idx), 16);
        flash_rdy = 1'b0;
    endtask

    task automatic t_read_underflow();
        logic [31:0] w;
        clr_model();
        start_xfer(1'b0, 8, 1'b0);
        repeat (3) @(negedge clk);
        hrd = 1'b1;
        @(negedge clk) hrd = 1'b0;
        check("R5 empty pop ignored", int'(status[13:0]), 8);
        flash_rdy = 1'b1;
        pull_word(w);
        check("R5 first word after ignored pop", int'(w), int'(exp_word(0)));
        pull_word(w);
        check("R8 second word", int'(w), int'(exp_word(4)));
        flash_rdy = 1'b0;
    endtask

    task automatic t_full_reject_stop();
        logic [31:0] w;
        clr_model();
        flash_rdy = 1'b1;
        start_xfer(1'b0, 200, 1'b0);
        repeat (80) @(negedge clk);
        check("R4 fill capped", int'(status[30:24]), 64);
        check("R4 fetch stalls at full", int'(fl_idx), 64);
        start_xfer(1'b1, 10, 1'b0);
        check("R9 reject pulse", int'(start_rej), 1);
        check("R9 count kept", int'(status[13:0]), 200);
        check("R9 mode kept", int'(status[30:24]), 64);
        stop_xfer();
        check("R10 stop clears status", int'(status), 0);
        flash_rdy = 1'b0;
        clr_model();
        @(negedge clk);
        cfg_write = 1'b0; cfg_count = 14'd8; start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check("R10 stop beats start", int'(status), 0);
        start_xfer(1'b0, 4, 1'b0);
        check("R10 start after stop", int'(status[13:0]), 4);
        check("R9 no reject when idle", int'(start_rej), 0);
        flash_rdy = 1'b1;
        pull_word(w);
        check("R5 data after restart", int'(w), int'(exp_word(0)));
        flash_rdy = 1'b0;
    endtask

    task automatic t_write_basic();
        int bad = 0;
        clr_model();
        start_xfer(1'b1, 11, 1'b0);
        check("R2 write count masked", int'(status[13:0]), 10);
        check("R3 write free space", int'(status[30:24]), 64);
        for (int i = 0; i < 5; i++) push_half({pat(100 + 2*i + 1), pat(100 + 2*i)});
        check("R3 free after pushes", int'(status[30:24]), 54);
        check("R8 no drain while not ready", int'(status[13:0]), 10);
        push_half(16'hBEEF);
        check("R6 surplus push dropped", int'(status[30:24]), 54);
        @(negedge clk) flash_rdy = 1'b1;
        repeat (3) @(negedge clk);
        flash_rdy = 1'b0;
        check("R7 three beats", wcnt, 3);
        check("R8 write remaining", int'(status[13:0]), 7);
        flash_rdy = 1'b1;
        repeat (10) @(negedge clk);
        flash_rdy = 1'b0;
        check("R7 all bytes written", wcnt, 10);
        for (int i = 0; i < 10; i++) if (wcap[i] != pat(100 + i)) bad++;
        check("R6 byte order", bad, 0);
        check("R8 write done", int'(status[13:0]), 0);
    endtask

    task automatic t_stream_overlap();
        int got = 0;
        int bad = 0;
        clr_model();
        flash_rdy = 1'b1;
        start_xfer(1'b0, 256, 1'b0);
        for (int c = 0; c < 2000 && got < 64; c++) begin
            @(negedge clk);
            hrd = 1'b0;
            if (status[30:24] >= 7'd4) begin
                if (hrd_data != exp_word(4 * got)) bad++;
                got++;
                hrd = 1'b1;
            end
        end
        @(negedge clk) hrd = 1'b0;
        flash_rdy = 1'b0;
        check("R5 stream words", got, 64);
        check("R4 stream data intact", bad, 0);
        check("R8 stream done", int'(status[13:0]), 0);
    endtask

    task automatic t_dma_read();
        logic [31:0] w;
        int waited = 0;
        clr_model();
        flash_rdy = 1'b1;
        start_xfer(1'b0, 128, 1'b1);
        while (!dma_req && waited < 200) begin @(negedge clk); waited++; end
        check("R11 read frame request", int'(dma_req), 1);
        check("R11 request at full frame", int'(status[30:24]), 64);
        for (int i = 0; i < 15; i++) pull_word(w);
        check("R11 held during frame", int'(dma_req), 1);
        pull_word(w);
        check("R11 drops after frame", int'(dma_req), 0);
        waited = 0;
        while (!dma_req && waited < 200) begin @(negedge clk); waited++; end
        check("R11 second frame request", int'(dma_req), 1);
        for (int i = 0; i < 16; i++) pull_word(w);
        check("R11 last word", int'(w), int'(exp_word(124)));
        check("R11 read done no request", int'({dma_req, status[13:0]}), 0);
        flash_rdy = 1'b0;
    endtask

    task automatic t_dma_write();
        clr_model();
        start_xfer(1'b1, 8, 1'b1);
        @(negedge clk);
        check("R11 write frame request", int'(dma_req), 1);
        for (int i = 0; i < 4; i++) push_half({pat(2*i + 1), pat(2*i)});
        check("R11 write frame closed", int'(dma_req), 0);
        flash_rdy = 1'b1;
        repeat (12) @(negedge clk);
        flash_rdy = 1'b0;
        check("R7 dma write drained", wcnt, 8);
        check("R8 dma write done", int'(status[13:0]), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        fl_clr = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fl_clr = 1'b0;
        t_reset();
        t_read_basic();
        t_read_underflow();
        t_full_reject_stop();
        t_write_basic();
        t_stream_overlap();
        t_dma_read();
        t_dma_write();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule